// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel

This block is one DMA channel that copies data from one memory region to another. Software loads four registers: a link pointer, a source address, a target address and a command word. It then pulses a start input. In fetch mode the channel first reads a 16-byte descriptor from memory into those four registers. In direct mode it runs with the values it already holds. Each burst reads a group of beats into a 32-byte staging buffer and then writes them all back out. A burst moves whichever is smaller: the burst size or the bytes still to go.

A command bit can place the source or the target under flow control. In that case the channel moves data only while the peripheral request input is high. When the request drops at the end of a burst, the channel raises an end-of-receive flag. It then stops, jumps to the next descriptor, or waits for the request to return, as selected by two mode inputs. When the count runs out, the channel either stops or follows the link pointer to the next descriptor without help from software. The link pointer may select a branch descriptor placed 32 bytes above the normal one. This happens when branching is enabled in the pointer and the compare-status input is high.

Top module: `dma_chain_chan`

## Requirements
- R1: After reset the channel is idle (`running`=0). `flag_stop` is 1, `flag_start`, `flag_end` and `flag_eor` are 0, and `mem_req` is 0.
- R2: While idle, `cfg_we` with `cfg_sel` 0/1/2/3 loads the link pointer, source, target or command register. A `go` pulse with `nofetch`=1 clears `flag_stop` and runs on the loaded registers without a descriptor fetch.
- R3: A `go` pulse with `nofetch`=0 first reads four 32-bit words into the link, source, target and command registers, in that order. The words come from the link pointer with bits [3:0] cleared. The address is raised by 32 when pointer bit 1 is set and `cmp_status` is 1.
- R4: Command bits [15:14] set the beat width: field 1 is 1 byte, 2 is 2 bytes, 3 (and 0) is 4 bytes. `mem_size` carries 0/1/2 for 1/2/4 bytes, with data right-justified on the data buses. Bits [17:16]=f set a burst size of 4<<f bytes.
- R5: Command bit 31 advances the source address by the beat width after each read beat. Bit 30 does the same for the target address after each write beat. A clear bit holds that address fixed.
- R6: A burst reads min(remaining, burst size) bytes into the buffer and only then writes them out. Only one beat is outstanding at a time. Address, direction and size hold while `mem_ready` is low.
- R7: Command bits [12:0] hold the remaining byte count. After every burst they are rewritten with the count still left.
- R8: Command bit 29 (source) or bit 28 (target) selects flow control. The matching address has bits [1:0] cleared when the descriptor is fetched. No burst starts while `periph_req` is low.
- R9: Under flow control, if `periph_req` is low when a burst ends, `flag_eor` is set. With bytes still left, the channel then does one of three things. With `eor_stop` it stops and sets `flag_stop`. Otherwise, with `eor_jump` in fetch mode, it fetches the next descriptor. Otherwise it waits and resumes when the request returns.
- R10: When the count is zero, `flag_end` is set if command bit 21 is set. The channel stops (`running`=0, `flag_stop`=1) if `nofetch`=1, link pointer bit 0 is set, or `eor_stop`=1.
- R11: When the count is zero and no stop condition holds, the channel fetches the descriptor named by the link pointer and continues.
- R12: A descriptor fetch whose command word has bit 22 set sets `flag_start`. `flag_clr` clears `flag_start`, `flag_end` and `flag_eor`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe (accepted while idle) |
| cfg_sel | input | 2 | Register select: 0 link, 1 source, 2 target, 3 command |
| cfg_wdata | input | 32 | Register write data |
| go | input | 1 | Start pulse (accepted while idle) |
| nofetch | input | 1 | Direct mode: run without descriptor fetches |
| eor_stop | input | 1 | Stop on end-of-receive and at count zero |
| eor_jump | input | 1 | Fetch next descriptor on end-of-receive |
| cmp_status | input | 1 | Compare-status level used for branch selection |
| periph_req | input | 1 | Peripheral request for flow-controlled transfers |
| flag_clr | input | 1 | Clears the start, end and end-of-receive flags |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | 32 | Beat byte address |
| mem_size | output | 2 | Beat width code: 0=1, 1=2, 2=4 bytes |
| mem_wdata | output | 32 | Write data, right-justified |
| mem_rdata | input | 32 | Read data, right-justified |
| mem_ready | input | 1 | Beat completes in this cycle |
| running | output | 1 | Channel active |
| flag_start | output | 1 | Descriptor fetched with start-flag bit |
| flag_end | output | 1 | Count reached zero with end-flag bit |
| flag_stop | output | 1 | Channel stopped |
| flag_eor | output | 1 | End-of-receive seen |
| cur_src | output | 32 | Current source address |
| cur_dst | output | 32 | Current target address |
| cur_cmd | output | 32 | Current command word with live count |

## Verification
Four properties are checked on every cycle. A pending beat holds its address and direction until ready. The burst byte counter stays below the burst length. The stop flag and the running state exclude each other. The end and end-of-receive flags rise only with a zero count or an active flow-control bit, respectively. Only the directed scenarios can show the data itself being moved correctly. They also cover descriptor chaining and branch selection, fixed-address targets, low-bit masking, and the three end-of-receive outcomes, which depend on peripheral request timing.

// File: rtl/dcc_pkg.sv
// Shared types and command-word bit positions for the DMA channel.
package dcc_pkg;
    localparam int WORD_W = 32;
    localparam int LEN_W  = 13;

    localparam int CB_INC_SRC  = 31;
    localparam int CB_INC_DST  = 30;
    localparam int CB_FLOW_SRC = 29;
    localparam int CB_FLOW_DST = 28;
    localparam int CB_START_EN = 22;
    localparam int CB_END_EN   = 21;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_READ,
        ST_WRITE
    } dcc_state_e;
endpackage

// File: rtl/dcc_cmd_decode.sv
// Command-word decoder.
// Turns the live command word into beat width, burst size and mode bits.
// Assumes burst sizes never exceed the staging buffer (BUF_BYTES >= 32).
module dcc_cmd_decode
    import dcc_pkg::*;
#(
    parameter int BUF_BYTES = 32,
    localparam int CW = $clog2(BUF_BYTES) + 1
) (
    input  logic [WORD_W-1:0] cmd,
    output logic [2:0]        beat_bytes,
    output logic [1:0]        size_code,
    output logic [CW-1:0]     burst_bytes,
    output logic              src_inc,
    output logic              dst_inc,
    output logic              flow_on,
    output logic              flow_src,
    output logic              flow_dst,
    output logic              end_en,
    output logic              start_en
);
    // Width field to byte count and bus size code; field 0 is treated as 4 bytes.
    always_comb begin
        unique case (cmd[15:14])
            2'd1:    begin beat_bytes = 3'd1; size_code = 2'd0; end
            2'd2:    begin beat_bytes = 3'd2; size_code = 2'd1; end
            default: begin beat_bytes = 3'd4; size_code = 2'd2; end
        endcase
    end

    // Burst size is four bytes shifted left by the two-bit field.
    assign burst_bytes = CW'(4) << cmd[17:16];

    assign src_inc  = cmd[CB_INC_SRC];
    assign dst_inc  = cmd[CB_INC_DST];
    assign flow_src = cmd[CB_FLOW_SRC];
    assign flow_dst = cmd[CB_FLOW_DST];
    assign flow_on  = flow_src | flow_dst;
    assign end_en   = cmd[CB_END_EN];
    assign start_en = cmd[CB_START_EN];
endmodule

// File: rtl/dcc_burst_buf.sv
// Burst staging buffer.
// Byte-addressed store written in the read phase and drained in the write phase.
// Assumes at most four bytes per beat, right-justified; indices wrap modulo the size.
module dcc_burst_buf #(
    parameter int BUF_BYTES = 32,
    localparam int IW = $clog2(BUF_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [2:0]    wr_cnt,
    input  logic [31:0]   wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [31:0]   rd_data
);
    logic [7:0] bytes_q [BUF_BYTES];

    // Store the valid low lanes of a read beat at consecutive byte slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < BUF_BYTES; i++) bytes_q[i] <= '0;
        end else if (wr_en) begin
            for (int k = 0; k < 4; k++) begin
                if (k < int'(wr_cnt)) bytes_q[IW'(wr_idx + IW'(k))] <= wr_data[8*k +: 8];
            end
        end
    end

    // Present four consecutive bytes from the drain index as one word.
    for (genvar g = 0; g < 4; g++) begin : g_lane
        logic [IW-1:0] lane_idx;
        assign lane_idx = rd_idx + IW'(g);
        assign rd_data[8*g +: 8] = bytes_q[lane_idx];
    end
endmodule

// File: rtl/dcc_engine.sv
// Channel sequencer.
// Holds the four channel registers and runs the fetch / check / read / write cycle.
// Assumes the memory side completes a beat in any cycle with mem_ready high
// while the request is up, and that burst sizes fit in the staging buffer.
module dcc_engine
    import dcc_pkg::*;
#(
    parameter int BUF_BYTES = 32,
    localparam int IW = $clog2(BUF_BYTES),
    localparam int CW = IW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              go,
    input  logic              nofetch,
    input  logic              eor_stop,
    input  logic              eor_jump,
    input  logic              cmp_status,
    input  logic              periph_req,
    input  logic              flag_clr,
    input  logic              mem_ready,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic [2:0]        beat_bytes,
    input  logic [CW-1:0]     burst_bytes,
    input  logic              src_inc,
    input  logic              dst_inc,
    input  logic              flow_on,
    input  logic              end_en,
    output dcc_state_e        state,
    output logic [WORD_W-1:0] fetch_addr,
    output logic [WORD_W-1:0] src_q,
    output logic [WORD_W-1:0] dst_q,
    output logic [WORD_W-1:0] cmd_q,
    output logic [IW-1:0]     buf_idx,
    output logic              flag_start,
    output logic              flag_end,
    output logic              flag_stop,
    output logic              flag_eor
);
    logic [WORD_W-1:0] ptr_q;
    logic [WORD_W-1:0] fbase_q;
    logic [1:0]        widx_q;
    logic [CW-1:0]     nb_q;
    logic [CW-1:0]     burst_q;

    logic [WORD_W-1:0] next_base;
    logic [LEN_W-1:0]  len_now;
    logic [LEN_W-1:0]  len_after;
    logic [CW-1:0]     burst_now;
    logic [CW-1:0]     nb_next;
    logic              stop_cond;
    logic              req_low;

    // Descriptor address from the link pointer, with the optional branch offset.
    assign next_base = {ptr_q[WORD_W-1:4], 4'b0000}
                     + ((ptr_q[1] && cmp_status) ? WORD_W'(32) : WORD_W'(0));

    assign len_now   = cmd_q[LEN_W-1:0];
    assign len_after = len_now - LEN_W'(burst_q);
    assign burst_now = (len_now < LEN_W'(burst_bytes)) ? CW'(len_now) : burst_bytes;
    assign nb_next   = nb_q + CW'(beat_bytes);
    assign stop_cond = nofetch || ptr_q[0] || eor_stop;
    assign req_low   = flow_on && !periph_req;
    assign fetch_addr = fbase_q + {28'd0, widx_q, 2'b00};
    assign buf_idx   = nb_q[IW-1:0];

    // Main sequencer: register loads, descriptor fetch, burst phases, flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            ptr_q      <= '0;
            src_q      <= '0;
            dst_q      <= '0;
            cmd_q      <= '0;
            fbase_q    <= '0;
            widx_q     <= '0;
            nb_q       <= '0;
            burst_q    <= '0;
            flag_start <= 1'b0;
            flag_end   <= 1'b0;
            flag_eor   <= 1'b0;
            flag_stop  <= 1'b1;
        end else begin
            if (flag_clr) begin
                flag_start <= 1'b0;
                flag_end   <= 1'b0;
                flag_eor   <= 1'b0;
            end
            unique case (state)
                ST_IDLE: begin
                    if (cfg_we) begin
                        unique case (cfg_sel)
                            2'd0: ptr_q <= cfg_wdata;
                            2'd1: src_q <= cfg_wdata;
                            2'd2: dst_q <= cfg_wdata;
                            default: cmd_q <= cfg_wdata;
                        endcase
                    end
                    if (go) begin
                        flag_stop <= 1'b0;
                        widx_q    <= '0;
                        fbase_q   <= next_base;
                        state     <= nofetch ? ST_CHECK : ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (mem_ready) begin
                        widx_q <= widx_q + 2'd1;
                        unique case (widx_q)
                            2'd0: ptr_q <= mem_rdata;
                            2'd1: src_q <= mem_rdata;
                            2'd2: dst_q <= mem_rdata;
                            default: begin
                                cmd_q <= mem_rdata;
                                if (mem_rdata[CB_FLOW_SRC]) src_q[1:0] <= 2'b00;
                                if (mem_rdata[CB_FLOW_DST]) dst_q[1:0] <= 2'b00;
                                if (mem_rdata[CB_START_EN]) flag_start <= 1'b1;
                                state <= ST_CHECK;
                            end
                        endcase
                    end
                end
                ST_CHECK: begin
                    if (len_now == '0) begin
                        if (end_en) flag_end <= 1'b1;
                        if (stop_cond) begin
                            flag_stop <= 1'b1;
                            state     <= ST_IDLE;
                        end else begin
                            fbase_q <= next_base;
                            widx_q  <= '0;
                            state   <= ST_FETCH;
                        end
                    end else if (!req_low) begin
                        burst_q <= burst_now;
                        nb_q    <= '0;
                        state   <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (mem_ready) begin
                        if (src_inc) src_q <= src_q + WORD_W'(beat_bytes);
                        if (nb_next >= burst_q) begin
                            nb_q  <= '0;
                            state <= ST_WRITE;
                        end else begin
                            nb_q <= nb_next;
                        end
                    end
                end
                ST_WRITE: begin
                    if (mem_ready) begin
                        if (dst_inc) dst_q <= dst_q + WORD_W'(beat_bytes);
                        if (nb_next >= burst_q) begin
                            nb_q <= '0;
                            cmd_q[LEN_W-1:0] <= len_after;
                            state <= ST_CHECK;
                            if (req_low) begin
                                flag_eor <= 1'b1;
                                if (len_after != '0) begin
                                    if (eor_stop) begin
                                        flag_stop <= 1'b1;
                                        state     <= ST_IDLE;
                                    end else if (eor_jump && !nofetch) begin
                                        fbase_q <= next_base;
                                        widx_q  <= '0;
                                        state   <= ST_FETCH;
                                    end
                                end
                            end
                        end else begin
                            nb_q <= nb_next;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R6
    burst_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ || state == ST_WRITE) |-> (nb_q < burst_q));

    // R10
    stop_vs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> !flag_stop);

    // R7
    end_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_end) |-> (cmd_q[LEN_W-1:0] == '0));

    // R9
    eor_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_eor) |-> (cmd_q[CB_FLOW_SRC] || cmd_q[CB_FLOW_DST]));
endmodule

// File: rtl/dma_chain_chan.sv
// Descriptor-chained DMA channel, top level.
// Wires the command decoder, the sequencer and the staging buffer to a
// single-beat memory master. Assumes one outstanding beat and right-justified data.
module dma_chain_chan
    import dcc_pkg::*;
#(
    parameter int BUF_BYTES = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_sel,
    input  logic [31:0] cfg_wdata,
    input  logic        go,
    input  logic        nofetch,
    input  logic        eor_stop,
    input  logic        eor_jump,
    input  logic        cmp_status,
    input  logic        periph_req,
    input  logic        flag_clr,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [1:0]  mem_size,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ready,
    output logic        running,
    output logic        flag_start,
    output logic        flag_end,
    output logic        flag_stop,
    output logic        flag_eor,
    output logic [31:0] cur_src,
    output logic [31:0] cur_dst,
    output logic [31:0] cur_cmd
);
    localparam int IW = $clog2(BUF_BYTES);
    localparam int CW = IW + 1;

    dcc_state_e        state;
    logic [WORD_W-1:0] fetch_addr, src_q, dst_q, cmd_q;
    logic [IW-1:0]     buf_idx;
    logic [2:0]        beat_bytes;
    logic [1:0]        size_code;
    logic [CW-1:0]     burst_bytes;
    logic              src_inc, dst_inc, flow_on, flow_src, flow_dst, end_en, start_en;
    logic [31:0]       buf_rd;

    dcc_cmd_decode #(.BUF_BYTES(BUF_BYTES)) u_dec (
        .cmd(cmd_q), .beat_bytes(beat_bytes), .size_code(size_code),
        .burst_bytes(burst_bytes), .src_inc(src_inc), .dst_inc(dst_inc),
        .flow_on(flow_on), .flow_src(flow_src), .flow_dst(flow_dst),
        .end_en(end_en), .start_en(start_en)
    );

    dcc_engine #(.BUF_BYTES(BUF_BYTES)) u_eng (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .go(go), .nofetch(nofetch), .eor_stop(eor_stop),
        .eor_jump(eor_jump), .cmp_status(cmp_status), .periph_req(periph_req),
        .flag_clr(flag_clr), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .beat_bytes(beat_bytes), .burst_bytes(burst_bytes), .src_inc(src_inc),
        .dst_inc(dst_inc), .flow_on(flow_on), .end_en(end_en), .state(state),
        .fetch_addr(fetch_addr), .src_q(src_q), .dst_q(dst_q), .cmd_q(cmd_q),
        .buf_idx(buf_idx), .flag_start(flag_start), .flag_end(flag_end),
        .flag_stop(flag_stop), .flag_eor(flag_eor)
    );

    dcc_burst_buf #(.BUF_BYTES(BUF_BYTES)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(state == ST_READ && mem_ready), .wr_idx(buf_idx),
        .wr_cnt(beat_bytes), .wr_data(mem_rdata),
        .rd_idx(buf_idx), .rd_data(buf_rd)
    );

    // Memory master outputs selected by the sequencer phase.
    always_comb begin
        mem_req  = (state == ST_FETCH) || (state == ST_READ) || (state == ST_WRITE);
        mem_we   = (state == ST_WRITE);
        mem_size = (state == ST_FETCH) ? 2'd2 : size_code;
        unique case (state)
            ST_FETCH: mem_addr = fetch_addr;
            ST_WRITE: mem_addr = dst_q;
            default:  mem_addr = src_q;
        endcase
        mem_wdata = (state == ST_WRITE) ? buf_rd : 32'd0;
    end

    assign running = (state != ST_IDLE);
    assign cur_src = src_q;
    assign cur_dst = dst_q;
    assign cur_cmd = cmd_q;

    // R6
    beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_size)));
endmodule

// File: tb/sim_dma_chain_chan.sv
module sim_dma_chain_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 0, go = 0, nofetch = 0, eor_stop = 0, eor_jump = 0;
    logic        cmp_status = 0, periph_req = 0, flag_clr = 0;
    logic [1:0]  cfg_sel = 0;
    logic [31:0] cfg_wdata = 0;
    logic        mem_req, mem_we, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_size;
    logic        running, flag_start, flag_end, flag_stop, flag_eor;
    logic [31:0] cur_src, cur_dst, cur_cmd;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dma_chain_chan u0 (.*);

    // Memory model: 1 KiB, one-cycle ready, right-justified lanes.
    logic [7:0] mem [0:1023];
    logic rdy;
    assign mem_ready = rdy;
    always_comb begin
        for (int k = 0; k < 4; k++)
            mem_rdata[8*k +: 8] = (k < (1 << mem_size)) ? mem[(mem_addr + k) & 32'h3FF] : 8'h00;
    end
    always @(posedge clk) begin
        if (!rst_n) rdy <= 1'b0;
        else begin
            rdy <= mem_req && !rdy;
            if (mem_req && mem_we && rdy)
                for (int k = 0; k < 4; k++)
                    if (k < (1 << mem_size)) mem[(mem_addr + k) & 32'h3FF] <= mem_wdata[8*k +: 8];
        end
    end

    task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic put32(int a, logic [31:0] v);
        for (int k = 0; k < 4; k++) mem[a + k] = v[8*k +: 8];
    endtask

    task automatic zero(int a, int n);
        for (int i = 0; i < n; i++) mem[a + i] = 8'h00;
    endtask

    function automatic logic [7:0] pat(int a);
        return 8'((a * 7 + 3) ^ 8'h5A);
    endfunction

    function automatic logic [31:0] mk(int len, int w, int b, bit is, bit it, bit fs, bit fd,
                                       bit en, bit st);
        logic [31:0] c = '0;
        c[12:0] = 13'(len); c[15:14] = 2'(w); c[17:16] = 2'(b);
        c[31] = is; c[30] = it; c[29] = fs; c[28] = fd; c[21] = en; c[22] = st;
        return c;
    endfunction

    task automatic cfg(int sel, logic [31:0] v);
        @(negedge clk); cfg_we = 1; cfg_sel = 2'(sel); cfg_wdata = v;
        @(negedge clk); cfg_we = 0;
    endtask

    task automatic start(bit nf);
        @(negedge clk); flag_clr = 1;
        @(negedge clk); flag_clr = 0; nofetch = nf; go = 1;
        @(negedge clk); go = 0;
    endtask

    task automatic wait_idle(string rq);
        int n = 0;
        while (running && n < 5000) begin @(negedge clk); n++; end
        chk({rq, " finish"}, 32'(running), 32'd0);
    endtask

    task automatic chk_copy(string rq, int s, int d, int n);
        for (int i = 0; i < n; i++) chk(rq, 32'(mem[d + i]), 32'(mem[s + i]));
    endtask

    task automatic drop_req_in_burst();
        int n = 0;
        while (!(mem_req && !mem_we && mem_addr >= 32'h200) && n < 2000) begin @(negedge clk); n++; end
        periph_req = 0;
    endtask

    task automatic t_reset();
        chk("R1 running", 32'(running), 0);
        chk("R1 stop", 32'(flag_stop), 1);
        chk("R1 start/end/eor", {29'd0, flag_start, flag_end, flag_eor}, 0);
        chk("R1 mem_req", 32'(mem_req), 0);
    endtask

    // Direct mode, 4-byte beats, 8-byte bursts, 12 bytes.
    task automatic t_direct();
        zero(12'h300, 16);
        cfg(0, 32'h1); cfg(1, 32'h200); cfg(2, 32'h300);
        cfg(3, mk(12, 3, 1, 1, 1, 0, 0, 1, 0));
        start(1);
        chk("R2 stop cleared", 32'(flag_stop), 0);
        wait_idle("R2");
        chk_copy("R2 R6 copy", 12'h200, 12'h300, 12);
        chk("R6 no overrun", 32'(mem[12'h30C]), 0);
        chk("R7 count", {19'd0, cur_cmd[12:0]}, 0);
        chk("R5 src adv", cur_src, 32'h20C);
        chk("R10 end", 32'(flag_end), 1);
        chk("R10 stop", 32'(flag_stop), 1);
    endtask

    // Two chained descriptors; second has stop bit.
    task automatic t_chain();
        zero(12'h320, 32);
        put32(12'h040, 32'h60); put32(12'h044, 32'h210); put32(12'h048, 32'h320);
        put32(12'h04C, mk(8, 2, 0, 1, 1, 0, 0, 0, 1));
        put32(12'h060, 32'h1); put32(12'h064, 32'h220); put32(12'h068, 32'h330);
        put32(12'h06C, mk(6, 1, 2, 1, 1, 0, 0, 1, 0));
        cfg(0, 32'h40);
        start(0);
        wait_idle("R11");
        chk_copy("R3 R11 first", 12'h210, 12'h320, 8);
        chk_copy("R11 second", 12'h220, 12'h330, 6);
        chk("R4 byte beats dst", cur_dst, 32'h336);
        chk("R12 start", 32'(flag_start), 1);
        chk("R10 end", 32'(flag_end), 1);
    endtask

    // Branch descriptor at pointer+32.
    task automatic t_branch();
        zero(12'h340, 32);
        put32(12'h080, 32'h1); put32(12'h084, 32'h240); put32(12'h088, 32'h350);
        put32(12'h08C, mk(4, 3, 0, 1, 1, 0, 0, 0, 0));
        put32(12'h0A0, 32'h1); put32(12'h0A4, 32'h230); put32(12'h0A8, 32'h340);
        put32(12'h0AC, mk(4, 3, 0, 1, 1, 0, 0, 0, 0));
        cmp_status = 1;
        cfg(0, 32'h8A);
        start(0);
        wait_idle("R3");
        cmp_status = 0;
        chk_copy("R3 branch", 12'h230, 12'h340, 4);
        chk("R3 not normal", {mem[12'h353], mem[12'h352], mem[12'h351], mem[12'h350]}, 0);
        chk("R12 no start", 32'(flag_start), 0);
    endtask

    // Fixed target, byte beats.
    task automatic t_fixed();
        zero(12'h360, 8);
        cfg(0, 32'h1); cfg(1, 32'h250); cfg(2, 32'h360);
        cfg(3, mk(5, 1, 1, 1, 0, 0, 0, 0, 0));
        start(1);
        wait_idle("R5");
        chk("R5 last byte", 32'(mem[12'h360]), 32'(mem[12'h254]));
        chk("R5 neighbour", 32'(mem[12'h361]), 0);
        chk("R5 dst fixed", cur_dst, 32'h360);
        chk("R5 src adv", cur_src, 32'h255);
        chk("R10 no end", 32'(flag_end), 0);
    endtask

    // Flow control: wait, mask, EOR stop.
    task automatic t_flow_stop();
        zero(12'h370, 16);
        put32(12'h0C0, 32'hE0); put32(12'h0C4, 32'h263); put32(12'h0C8, 32'h370);
        put32(12'h0CC, mk(16, 3, 1, 1, 1, 1, 0, 0, 0));
        periph_req = 0; eor_stop = 1;
        cfg(0, 32'hC0);
        start(0);
        repeat (30) @(negedge clk);
        chk("R8 waiting", 32'(running), 1);
        chk("R8 masked", cur_src, 32'h260);
        chk("R8 no move", {19'd0, cur_cmd[12:0]}, 16);
        periph_req = 1;
        drop_req_in_burst();
        wait_idle("R9");
        eor_stop = 0;
        chk("R9 eor", 32'(flag_eor), 1);
        chk("R9 stop", 32'(flag_stop), 1);
        chk("R7 left", {19'd0, cur_cmd[12:0]}, 8);
        chk_copy("R9 first burst", 12'h260, 12'h370, 8);
        chk("R9 rest untouched", {mem[12'h37B], mem[12'h37A], mem[12'h379], mem[12'h378]}, 0);
    endtask

    // Flow control: EOR then wait and resume.
    task automatic t_flow_resume();
        zero(12'h380, 16);
        put32(12'h0C0, 32'h1); put32(12'h0C4, 32'h260); put32(12'h0C8, 32'h380);
        put32(12'h0CC, mk(16, 3, 1, 1, 1, 1, 0, 1, 0));
        cfg(0, 32'hC0);
        periph_req = 1;
        start(0);
        drop_req_in_burst();
        repeat (40) @(negedge clk);
        chk("R9 wait running", 32'(running), 1);
        chk("R9 wait eor", 32'(flag_eor), 1);
        chk("R7 paused count", {19'd0, cur_cmd[12:0]}, 8);
        periph_req = 1;
        wait_idle("R9 resume");
        periph_req = 0;
        chk_copy("R9 resumed copy", 12'h260, 12'h380, 16);
        chk("R10 end", 32'(flag_end), 1);
    endtask

    // Flow control: EOR jump to next descriptor.
    task automatic t_flow_jump();
        zero(12'h390, 16); zero(12'h3A0, 8);
        put32(12'h0C0, 32'hE0); put32(12'h0C4, 32'h260); put32(12'h0C8, 32'h390);
        put32(12'h0CC, mk(16, 3, 1, 1, 1, 1, 0, 0, 0));
        put32(12'h0E0, 32'h1); put32(12'h0E4, 32'h270); put32(12'h0E8, 32'h3A0);
        put32(12'h0EC, mk(4, 3, 0, 1, 1, 0, 0, 0, 1));
        eor_jump = 1; periph_req = 1;
        cfg(0, 32'hC0);
        start(0);
        drop_req_in_burst();
        wait_idle("R9 jump");
        eor_jump = 0;
        chk_copy("R9 jump target", 12'h270, 12'h3A0, 4);
        chk("R9 skipped rest", {mem[12'h39B], mem[12'h39A], mem[12'h399], mem[12'h398]}, 0);
        chk("R9 eor", 32'(flag_eor), 1);
        chk("R12 start on jump", 32'(flag_start), 1);
        @(negedge clk); flag_clr = 1; @(negedge clk); flag_clr = 0;
        chk("R12 clear", {29'd0, flag_start, flag_end, flag_eor}, 0);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = pat(i);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_direct();
        t_chain();
        t_branch();
        t_fixed();
        t_flow_stop();
        t_flow_resume();
        t_flow_jump();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule